// File: doc/BRIEF.md
# Byte-Register 1-Wire Bus Master

This block lets a host run a 1-Wire bus one bit at a time through a small byte-wide register window. The host writes a command bit into the control register. The block then plays out one timed operation on the open-drain line: a reset pulse followed by a presence check, a write-0 slot, or a write-1 slot that also reads the bus. The command bit reads back as 1 for as long as the operation runs and clears itself when the operation finishes. The result of the presence check and the bit sampled during the last read slot stay visible in two status bits.

All slot timing is counted in ticks of a time base. The host sets that time base through a divider register. The register holds N-1, where N is the clock frequency in MHz rounded to the nearest integer, so one tick lasts about 1 µs. With the default divider of 0, one tick lasts one clock. The line input passes through a parameterised synchroniser before it is sampled. A separate abort register returns the block to idle at any time. Byte sequencing, ROM search, CRC and interrupts belong to the software above the block.

Register map (byte offsets): control at 0x00, divider at 0x02, abort at 0x04.

Top module: `owire_host`

## Requirements
- R1: After reset, control (0x00) reads 0x00, the divider (0x02) reads 0x00 and `line_pull_low` is 0.
- R2: The divider register at offset 0x02 reads back what was written, and the abort register at 0x04 reads 0x00. With divider value D, one tick lasts D+1 clocks, and every duration below scales by D+1.
- R3: Writing a 1 to control bit 7 while idle starts a reset sequence. The line is pulled low for 480 ticks, and bit 7 reads 1 for exactly 960 ticks before it clears.
- R4: Control bit 6 (presence) takes the inverse of the line value sampled as the tick count of a reset sequence reaches 550. It holds that value until the next such sample or an abort.
- R5: Writing a 1 to control bit 5 while idle starts a write-0 slot. The line is pulled low for 60 ticks, and bit 5 reads 1 for 70 ticks. Control bit 3 is not changed.
- R6: Writing a 1 to control bit 4 while idle starts a read slot. The line is pulled low for 6 ticks, and bit 4 reads 1 for 70 ticks. Control bit 3 takes the line value sampled as the tick count reaches 15.
- R7: A control write that arrives while an operation is running has no effect on that operation or on the command bits.
- R8: When one write sets several command bits, only one is accepted, in the order bit 7, then bit 5, then bit 4. Only the accepted bit reads back as 1.
- R9: Writing a value with bit 0 set to offset 0x04 ends any operation at the next clock edge. Control then reads 0x00 (presence and read bit cleared) and the line is released. A write to 0x04 with bit 0 clear has no effect.
- R10: The line input passes through SYNC_STAGES flip-flops (default 2) before it is sampled, so the sampled value is the line level SYNC_STAGES clocks before the sampling edge.
- R11: `line_pull_low` is asserted only during the low phase of an accepted operation, and the line is released at every other time.
- R12: A control write with none of bits 7, 5 and 4 set leaves the control register unchanged, including the read-only bits 6 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at least 10 MHz for correct bus timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| line_pull_low | output | 1 | 1 = pull the open-drain line low, 0 = release it |
| line_sense | input | 1 | Level of the 1-Wire line |

## Verification
The hardest condition to reach is a sample that falls on exactly the right clock. Every sample is taken at the edge where the tick count reaches its sample point, after the synchroniser delay. The bench acts as a slave: it pulls the line low for a single clock, placed at an index computed from the divider and the synchroniser depth. It also places the same pulse one clock early and one clock late, which must be missed. This is repeated for several divider values. Aborts and writes while busy are injected at chosen cycle indices inside a running operation, and durations are counted clock by clock against multiples of D+1.

// File: rtl/owire_pkg.sv
package owire_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_RESET = 2'd1,
      OP_WR0   = 2'd2,
      OP_WR1   = 2'd3
   } op_e;

   // control register bit positions (host software decodes these)
   localparam int unsigned CTL_RST_BIT  = 7;
   localparam int unsigned CTL_PRES_BIT = 6;
   localparam int unsigned CTL_W0_BIT   = 5;
   localparam int unsigned CTL_W1_BIT   = 4;
   localparam int unsigned CTL_RD_BIT   = 3;
   localparam int unsigned ABORT_BIT    = 0;

   localparam int unsigned REG_W = 8;

endpackage

// File: rtl/owire_tick.sv
module owire_tick #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (restart || !run) begin
         pre_q <= '0;
      end else if (pre_q == div) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign tick = run && !restart && (pre_q == div);

   // R2: with a non-zero, unchanged divider two ticks never touch
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && !restart) |=> (!tick || !$stable(div)));

endmodule

// File: rtl/owire_seq.sv
module owire_seq
   import owire_pkg::*;
#(
   parameter int unsigned RST_LOW_T    = 480,
   parameter int unsigned RST_SAMPLE_T = 550,
   parameter int unsigned RST_WIN_T    = 960,
   parameter int unsigned W0_LOW_T     = 60,
   parameter int unsigned W1_LOW_T     = 6,
   parameter int unsigned W1_SAMPLE_T  = 15,
   parameter int unsigned SLOT_T       = 60,
   parameter int unsigned RECOV_T      = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  op_e  start_op,
   input  logic abort_i,
   input  logic tick,
   output op_e  op_o,
   output logic pull_low_o,
   output logic sample_stb_o,
   output logic done_o
);

   localparam int unsigned CNT_W = $clog2(RST_WIN_T + 1);
   localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_WIN_T - 1);
   localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_T + RECOV_T - 1);
   localparam logic [CNT_W-1:0] RST_SMP   = CNT_W'(RST_SAMPLE_T - 1);
   localparam logic [CNT_W-1:0] W1_SMP    = CNT_W'(W1_SAMPLE_T - 1);
   localparam logic [CNT_W-1:0] RST_LOW   = CNT_W'(RST_LOW_T);
   localparam logic [CNT_W-1:0] W0_LOW    = CNT_W'(W0_LOW_T);
   localparam logic [CNT_W-1:0] W1_LOW    = CNT_W'(W1_LOW_T);

   op_e              op_q;
   logic [CNT_W-1:0] t_q;
   logic [CNT_W-1:0] t_last;
   logic [CNT_W-1:0] t_smp;
   logic             has_smp;

   always_comb begin
      t_last  = SLOT_LAST;
      t_smp   = W1_SMP;
      has_smp = 1'b0;
      unique case (op_q)
         OP_RESET: begin
            t_last  = RST_LAST;
            t_smp   = RST_SMP;
            has_smp = 1'b1;
         end
         OP_WR1:   has_smp = 1'b1;
         default:  has_smp = 1'b0;
      endcase
   end

   always_comb begin
      unique case (op_q)
         OP_RESET: pull_low_o = (t_q < RST_LOW);
         OP_WR0:   pull_low_o = (t_q < W0_LOW);
         OP_WR1:   pull_low_o = (t_q < W1_LOW);
         default:  pull_low_o = 1'b0;
      endcase
   end

   assign done_o       = tick && (op_q != OP_IDLE) && (t_q == t_last);
   assign sample_stb_o = tick && has_smp && (t_q == t_smp);
   assign op_o         = op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= OP_IDLE;
         t_q  <= '0;
      end else if (abort_i) begin
         op_q <= OP_IDLE;
         t_q  <= '0;
      end else if (op_q == OP_IDLE) begin
         if (start_op != OP_IDLE) begin
            op_q <= start_op;
            t_q  <= '0;
         end
      end else if (tick) begin
         if (done_o) begin
            op_q <= OP_IDLE;
            t_q  <= '0;
         end else begin
            t_q <= t_q + 1'b1;
         end
      end
   end

   // R7: a running operation keeps its kind until it completes or is aborted
   assert_op_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_IDLE && !abort_i && !done_o) |=> (op_q == $past(op_q)));

   // R3: the tick count never passes the last tick of the operation
   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_IDLE) |-> (t_q <= t_last));

   // R9: an abort leaves the sequencer idle with the line released
   assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (op_q == OP_IDLE && !pull_low_o));

endmodule

// File: rtl/owire_regs.sv
module owire_regs
   import owire_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned DIV_RESET = 0,
   parameter int unsigned CTRL_OFF  = 0,
   parameter int unsigned DIV_OFF   = 2,
   parameter int unsigned ABORT_OFF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  op_e               op,
   input  logic              done,
   input  logic              sample_stb,
   input  logic              sample_val,
   output op_e               start_op,
   output logic              abort_o,
   output logic [DIV_W-1:0]  div_o
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFF);
   localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(DIV_OFF);
   localparam logic [ADDR_W-1:0] A_ABORT = ADDR_W'(ABORT_OFF);

   logic       wr_ctl;
   logic       wr_div;
   logic [2:0] cmd_q;      // {reset, write-0, write-1/read}
   logic       pres_q;
   logic       rd_q;
   logic [DIV_W-1:0] div_q;

   assign wr_ctl  = bus_sel && bus_we && (bus_addr == A_CTRL);
   assign wr_div  = bus_sel && bus_we && (bus_addr == A_DIV);
   assign abort_o = bus_sel && bus_we && (bus_addr == A_ABORT) && bus_wdata[ABORT_BIT];

   // fixed acceptance order: reset, then write-0, then write-1/read
   always_comb begin
      start_op = OP_IDLE;
      if (wr_ctl && op == OP_IDLE) begin
         if (bus_wdata[CTL_RST_BIT])     start_op = OP_RESET;
         else if (bus_wdata[CTL_W0_BIT]) start_op = OP_WR0;
         else if (bus_wdata[CTL_W1_BIT]) start_op = OP_WR1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         pres_q <= 1'b0;
         rd_q   <= 1'b0;
         div_q  <= DIV_W'(DIV_RESET);
      end else begin
         if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
         if (abort_o) begin
            cmd_q  <= '0;
            pres_q <= 1'b0;
            rd_q   <= 1'b0;
         end else begin
            if (start_op != OP_IDLE) begin
               cmd_q <= {start_op == OP_RESET, start_op == OP_WR0, start_op == OP_WR1};
            end else if (done) begin
               cmd_q <= '0;
            end
            if (sample_stb && op == OP_RESET) pres_q <= !sample_val;
            if (sample_stb && op == OP_WR1)   rd_q   <= sample_val;
         end
      end
   end

   assign div_o = div_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL) begin
         bus_rdata[CTL_RST_BIT]  = cmd_q[2];
         bus_rdata[CTL_PRES_BIT] = pres_q;
         bus_rdata[CTL_W0_BIT]   = cmd_q[1];
         bus_rdata[CTL_W1_BIT]   = cmd_q[0];
         bus_rdata[CTL_RD_BIT]   = rd_q;
      end else if (bus_addr == A_DIV) begin
         bus_rdata = REG_W'(div_q);
      end
   end

   // R7: a command bit is visible exactly while the sequencer is busy
   assert_cmd_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cmd_q) == (op != OP_IDLE)));

   // R8: at most one command bit is ever set
   assert_cmd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_q));

   // R4: presence changes only on a sample or an abort
   assert_pres_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pres_q) |-> $past(sample_stb || abort_o));

endmodule

// File: rtl/owire_host.sv
module owire_host
   import owire_pkg::*;
#(
   parameter int unsigned ADDR_W       = 3,
   parameter int unsigned DIV_W        = 8,
   parameter int unsigned DIV_RESET    = 0,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned CTRL_OFF     = 0,
   parameter int unsigned DIV_OFF      = 2,
   parameter int unsigned ABORT_OFF    = 4,
   parameter int unsigned RST_LOW_T    = 480,
   parameter int unsigned RST_SAMPLE_T = 550,
   parameter int unsigned RST_WIN_T    = 960,
   parameter int unsigned W0_LOW_T     = 60,
   parameter int unsigned W1_LOW_T     = 6,
   parameter int unsigned W1_SAMPLE_T  = 15,
   parameter int unsigned SLOT_T       = 60,
   parameter int unsigned RECOV_T      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              line_pull_low,
   input  logic              line_sense
);

   // elaboration-time parameter checks
   if (DIV_W < 1 || DIV_W > REG_W) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must not exceed 4");
   end
   if (CTRL_OFF == DIV_OFF || CTRL_OFF == ABORT_OFF || DIV_OFF == ABORT_OFF) begin : g_bad_map
      $error("register offsets must differ");
   end
   if (RST_SAMPLE_T <= RST_LOW_T || RST_WIN_T <= RST_SAMPLE_T) begin : g_bad_rst
      $error("reset timing must satisfy low < sample < window");
   end
   if (W1_SAMPLE_T <= W1_LOW_T || W1_SAMPLE_T > SLOT_T || W0_LOW_T > SLOT_T) begin : g_bad_slot
      $error("slot timing out of order");
   end
   if (RECOV_T < 1 || SLOT_T + RECOV_T > RST_WIN_T) begin : g_bad_rec
      $error("recovery time out of range");
   end

   op_e              op;
   op_e              start_op;
   logic             abort;
   logic             tick;
   logic             done;
   logic             sample_stb;
   logic             sense_s;
   logic [DIV_W-1:0] div;

   // line input synchroniser: a parameter picks the variant
   if (SYNC_STAGES == 0) begin : g_nosync
      assign sense_s = line_sense;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '1;
         end else begin
            sh_q[0] <= line_sense;
            for (int k = 1; k < SYNC_STAGES; k++) sh_q[k] <= sh_q[k-1];
         end
      end
      assign sense_s = sh_q[SYNC_STAGES-1];
   end

   owire_regs #(
      .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET),
      .CTRL_OFF(CTRL_OFF), .DIV_OFF(DIV_OFF), .ABORT_OFF(ABORT_OFF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .op(op), .done(done), .sample_stb(sample_stb), .sample_val(sense_s),
      .start_op(start_op), .abort_o(abort), .div_o(div)
   );

   owire_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n),
      .run(op != OP_IDLE), .restart(start_op != OP_IDLE),
      .div(div), .tick(tick)
   );

   owire_seq #(
      .RST_LOW_T(RST_LOW_T), .RST_SAMPLE_T(RST_SAMPLE_T), .RST_WIN_T(RST_WIN_T),
      .W0_LOW_T(W0_LOW_T), .W1_LOW_T(W1_LOW_T), .W1_SAMPLE_T(W1_SAMPLE_T),
      .SLOT_T(SLOT_T), .RECOV_T(RECOV_T)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_op(start_op), .abort_i(abort), .tick(tick),
      .op_o(op), .pull_low_o(line_pull_low),
      .sample_stb_o(sample_stb), .done_o(done)
   );

   // R11: the line only starts being pulled right after an accepted command
   assert_pull_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull_low) |-> $past(start_op != OP_IDLE));

endmodule

// File: tb/owire_host_bench.sv
module owire_host_bench;

   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_sel;
   logic       bus_we;
   logic [2:0] bus_addr;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic       line_pull_low;
   logic       slave_low;
   logic       line_sense;

   int  checks = 0;
   int  fails  = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   assign line_sense = !(line_pull_low || slave_low);

   owire_host u_owire_host (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .line_pull_low(line_pull_low), .line_sense(line_sense)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 3'd0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = 3'd0;
   endtask

   // Starts an operation and counts, clock by clock, the cycles with the line
   // pulled and the cycles with a command bit set. The cycle right after an
   // injected write to a non-control offset is not tested for completion.
   task automatic run_op(input logic [7:0] cmd, input int pulse_idx,
                         input int inj_idx, input logic [2:0] inj_addr,
                         input logic [7:0] inj_data,
                         output int low_cnt, output int busy_cnt,
                         output logic [7:0] first_ctl, output logic [7:0] last_ctl);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = cmd;
      @(negedge clk);
      low_cnt = 0; busy_cnt = 0; first_ctl = 8'h00; last_ctl = 8'h00;
      for (int i = 0; i < 4000; i++) begin
         if (i == 0) first_ctl = bus_rdata;
         if (line_pull_low) low_cnt++;
         if (bus_addr == 3'd0) begin
            if ((bus_rdata & 8'hB0) == 8'h00) begin
               last_ctl = bus_rdata;
               break;
            end
            busy_cnt++;
         end
         bus_we = 1'b0; bus_addr = 3'd0;
         if (i == inj_idx) begin
            bus_we = 1'b1; bus_addr = inj_addr; bus_wdata = inj_data;
         end
         slave_low = (i == pulse_idx);
         @(negedge clk);
      end
      bus_we = 1'b0; bus_addr = 3'd0; slave_low = 1'b0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v, v2, fc, lc;
      int lo, bz, m, j, p;
      rst_n = 1'b0; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd0;
      bus_wdata = 8'h00; slave_low = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_read(3'd0, v);  check("R1 ctrl", v, 8'h00);
      reg_read(3'd2, v);  check("R1 div", v, 8'h00);
      check("R1 line", line_pull_low, 0);

      // R2 divider and abort readback
      reg_write(3'd2, 8'h5A);
      reg_read(3'd2, v);  check("R2 div rw", v, 8'h5A);
      reg_read(3'd4, v);  check("R2 abort reads 0", v, 8'h00);

      for (int d = 0; d < 3; d++) begin
         m = d + 1;
         reg_write(3'd2, 8'(d));
         // R5 write-0
         run_op(8'h20, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R5 w0 cmd bit", fc & 8'hB0, 8'h20);
         check("R5 w0 low", lo, 60 * m);
         check("R5 w0 busy", bz, 70 * m);
         // R6 read with idle line
         run_op(8'h10, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R6 rd low", lo, 6 * m);
         check("R6 rd busy", bz, 70 * m);
         check("R6 rd high", lc[3], 1);
         run_op(8'h20, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R5 w0 keeps bit3", lc[3], 1);
         // R10 sample point: one-clock slave pulse on, before and after
         j = 15 * m - SYNC;
         run_op(8'h10, j - 1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R10 rd pulse on sample", lc[3], 0);
         run_op(8'h10, j - 2, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R10 rd pulse early", lc[3], 1);
         run_op(8'h10, j, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R10 rd pulse late", lc[3], 1);
         // R3/R4 reset sequence
         run_op(8'h80, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R3 rst low", lo, 480 * m);
         check("R3 rst busy", bz, 960 * m);
         check("R4 no presence", lc[6], 0);
         p = 550 * m - SYNC;
         run_op(8'h80, p - 1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R4 presence", lc[6], 1);
         run_op(8'h80, p - 2, -1, 3'd0, 8'h00, lo, bz, fc, lc);
         check("R4 presence early pulse", lc[6], 0);
      end
      reg_write(3'd2, 8'h00);

      // R12 write without command bits
      run_op(8'h10, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
      run_op(8'h80, 550 - SYNC - 1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
      reg_read(3'd0, v);
      check("R4 R6 status hold", v, 8'h48);
      reg_write(3'd0, 8'h00);
      reg_read(3'd0, v2); check("R12 write 00", v2, v);
      reg_write(3'd0, 8'h08);
      reg_read(3'd0, v2); check("R12 write 08", v2, v);

      // R7 command while busy
      run_op(8'h10, -1, 3, 3'd0, 8'h80, lo, bz, fc, lc);
      check("R7 cmd bit", fc & 8'hB0, 8'h10);
      check("R7 low", lo, 6);
      check("R7 busy", bz, 70);
      check("R7 no reset after", lc[7], 0);

      // R8 priority
      run_op(8'hB0, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
      check("R8 B0 bits", fc & 8'hB0, 8'h80);
      check("R8 B0 low", lo, 480);
      run_op(8'h30, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
      check("R8 30 bits", fc & 8'hB0, 8'h20);
      check("R8 30 low", lo, 60);

      // R9 abort register with bit 0 clear
      run_op(8'h20, -1, 10, 3'd4, 8'hFE, lo, bz, fc, lc);
      check("R9 no abort low", lo, 60);
      check("R9 no abort busy", bz, 69);

      // R9 abort mid reset, with status bits set beforehand
      run_op(8'h10, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
      run_op(8'h80, 550 - SYNC - 1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
      check("R9 status before abort", lc, 8'h48);
      run_op(8'h80, -1, 100, 3'd4, 8'h01, lo, bz, fc, lc);
      check("R9 abort low", lo, 101);
      check("R9 abort busy", bz, 101);
      reg_read(3'd0, v);  check("R9 ctrl cleared", v, 8'h00);
      check("R11 released after abort", line_pull_low, 0);
      run_op(8'h20, -1, -1, 3'd0, 8'h00, lo, bz, fc, lc);
      check("R9 usable after abort", bz, 70);
      @(negedge clk);
      check("R11 released when idle", line_pull_low, 0);

      finish_run();
   end

endmodule